// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between the running source clocks of a clock generator and its output pins. It gates a differential processor clock pair and a group of PCI clocks in answer to three active-low requests: a processor-clock stop, a PCI-clock stop and a full power-down. Each request is brought into the clock domain it controls through a synchroniser. The gate only changes state at a point in the clock period where the change cannot shorten a pulse, so every stop and restart is free of glitches. Stopped outputs settle at fixed parked levels.

The stopped processor pair parks with its true leg high and its complement leg low. Stoppable PCI outputs park low. A power-down request drives every output low, including the one PCI output that never obeys the PCI stop. A power-good input, active low, enables the outputs. Until that input has gone high and then fallen for the first time, all outputs are held low. After that first fall, the input is never looked at again.

Top module: `clkStopSeq`

## Requirements
- R1: While the processor stop request is low, the pair parks with cpuT = 1 and cpuC = 0. The park takes effect at the second falling edge of cpuClk (a rising edge of the complement leg) after the request goes low.
- R2: When the processor stop request returns high, the pair resumes at the second falling edge of cpuClk after the release. At that edge cpuT falls and cpuC rises together, so the first high phase is never shorter than a normal one.
- R3: While the PCI stop request is low, every bit of pciOut is held low from the second falling edge of pciClk onward. pciFree keeps following pciClk.
- R4: While the power-down request is low, cpuT, cpuC, pciFree and all pciOut bits are low. This is taken up two falling edges after the request in each domain, and it overrides both stop requests.
- R5: After reset, all outputs stay low until the power-good input has been seen high and then low in that domain.
- R6: Once a domain has been enabled by power-good, later changes on the power-good input have no effect on its outputs.
- R7: During reset, all outputs are low.
- R8: When a domain is running, cpuT equals cpuClk and cpuC equals its inverse, and pciFree and every pciOut bit equal pciClk.
- R9: A request for one domain never changes the outputs of the other domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Running source for the processor pair |
| pciClk | input | 1 | Running source for the PCI group |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuStopN | input | 1 | Processor pair stop request, active low |
| pciStopN | input | 1 | Stoppable PCI group stop request, active low |
| pdN | input | 1 | Power-down request, active low |
| pwrGoodN | input | 1 | Power-good, acts only on its first fall |
| cpuT | output | 1 | Processor pair, true leg |
| cpuC | output | 1 | Processor pair, complement leg |
| pciFree | output | 1 | Free-running PCI output |
| pciOut | output | NUM_PCI | Stoppable PCI outputs |

## Verification
The hardest situation to reach is a release of a stop or power-down request while the other domain is changing state, at a clock period that differs from the one that sampled the release. Only then do the two-edge delays of the two domains show up at different times. The stimulus runs two clocks whose periods are in a 1:3 ratio. Random toggling of all four requests, at a fixed time in the processor period, produces many stop/release edges that overlap with power-down and with PCI stop changes. A reference model in the bench tracks the two sampling edges for each domain and compares the outputs in both phases of every clock period. Directed phases come first: reset, the wait for power-good, and the toggling of power-good after the domains are enabled.

// File: rtl/clkStopSeq_pkg.sv
package clkStopSeq_pkg;

  // Number of independently sequenced clock domains and their indices.
  localparam int NUM_DOM = 2;
  localparam int DOM_CPU = 0;
  localparam int DOM_PCI = 1;

  // Strobes from control to the gating datapath.
  typedef struct packed {
    logic cpuOff;   // processor pair forced low
    logic cpuStop;  // processor pair parked true-high / complement-low
    logic pciOff;   // whole PCI group, free one included, forced low
    logic pciStop;  // stoppable PCI outputs held low
  } gateStrobe_t;

endpackage

// File: rtl/clkReqSync.sv
// Multi-stage synchroniser. It samples on the falling edge of the domain
// clock, which is where the gate of every output in that domain may change.
module clkReqSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/clkDomainCtrl.sv
// Request sequencing for one clock domain: synchronises its stop, power-down
// and power-good inputs and keeps the sticky enable set by power-good.
module clkDomainCtrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic stopN,
  input  logic pdN,
  input  logic pwrGoodN,
  output logic offReq,
  output logic stopReq
);

  logic stopSync;
  logic pdSync;
  logic pgSync;
  logic pgSeenHigh;
  logic enabled;

  clkReqSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_stopSync (
    .clk (clk), .rstN(rstN), .din(stopN), .dout(stopSync)
  );

  clkReqSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pdSync (
    .clk (clk), .rstN(rstN), .din(pdN), .dout(pdSync)
  );

  // Reset value low so that only a real high level counts as "seen high".
  clkReqSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pgSync (
    .clk (clk), .rstN(rstN), .din(pwrGoodN), .dout(pgSync)
  );

  // Enable once on the first high-to-low of power-good, then never look back.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      pgSeenHigh <= 1'b0;
      enabled    <= 1'b0;
    end else if (!enabled) begin
      if (pgSync)                   pgSeenHigh <= 1'b1;
      if (pgSeenHigh && !pgSync)    enabled    <= 1'b1;
    end
  end

  assign offReq  = !enabled || !pdSync;
  assign stopReq = !stopSync;

endmodule

// File: rtl/clkStopCtrl.sv
// One sequencer per domain, built from a clock array so both stay identical.
module clkStopCtrl
  import clkStopSeq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        cpuClk,
  input  logic        pciClk,
  input  logic        rstN,
  input  logic        cpuStopN,
  input  logic        pciStopN,
  input  logic        pdN,
  input  logic        pwrGoodN,
  output gateStrobe_t strobe
);

  logic [NUM_DOM-1:0] domClk;
  logic [NUM_DOM-1:0] domStopN;
  logic [NUM_DOM-1:0] domOff;
  logic [NUM_DOM-1:0] domStop;

  always_comb begin
    domClk[DOM_CPU]   = cpuClk;
    domClk[DOM_PCI]   = pciClk;
    domStopN[DOM_CPU] = cpuStopN;
    domStopN[DOM_PCI] = pciStopN;
  end

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      clkDomainCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_dom (
        .clk     (domClk[d]),
        .rstN    (rstN),
        .stopN   (domStopN[d]),
        .pdN     (pdN),
        .pwrGoodN(pwrGoodN),
        .offReq  (domOff[d]),
        .stopReq (domStop[d])
      );
    end
  endgenerate

  always_comb begin
    strobe.cpuOff  = domOff[DOM_CPU];
    strobe.cpuStop = domStop[DOM_CPU];
    strobe.pciOff  = domOff[DOM_PCI];
    strobe.pciStop = domStop[DOM_PCI];
  end

endmodule

// File: rtl/clkGateDp.sv
// Output gating. Strobes only change on the falling edge of their source,
// which is the point where each parked level matches the running waveform.
module clkGateDp
  import clkStopSeq_pkg::*;
#(
  parameter int NUM_PCI = 6
) (
  input  logic               cpuClk,
  input  logic               pciClk,
  input  gateStrobe_t        strobe,
  output logic               cpuT,
  output logic               cpuC,
  output logic               pciFree,
  output logic [NUM_PCI-1:0] pciOut
);

  logic pciGroupRun;

  always_comb begin
    if (strobe.cpuOff) begin
      cpuT = 1'b0;
      cpuC = 1'b0;
    end else if (strobe.cpuStop) begin
      cpuT = 1'b1;
      cpuC = 1'b0;
    end else begin
      cpuT = cpuClk;
      cpuC = ~cpuClk;
    end
  end

  assign pciFree     = pciClk & ~strobe.pciOff;
  assign pciGroupRun = ~strobe.pciOff & ~strobe.pciStop;

  generate
    for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci
      assign pciOut[i] = pciClk & pciGroupRun;
    end
  endgenerate

endmodule

// File: rtl/clkStopSeq.sv
module clkStopSeq
  import clkStopSeq_pkg::*;
#(
  parameter int NUM_PCI     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cpuClk,
  input  logic               pciClk,
  input  logic               rstN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               pdN,
  input  logic               pwrGoodN,
  output logic               cpuT,
  output logic               cpuC,
  output logic               pciFree,
  output logic [NUM_PCI-1:0] pciOut
);

  gateStrobe_t strobe;

  clkStopCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .cpuClk  (cpuClk),
    .pciClk  (pciClk),
    .rstN    (rstN),
    .cpuStopN(cpuStopN),
    .pciStopN(pciStopN),
    .pdN     (pdN),
    .pwrGoodN(pwrGoodN),
    .strobe  (strobe)
  );

  clkGateDp #(.NUM_PCI(NUM_PCI)) u_dp (
    .cpuClk (cpuClk),
    .pciClk (pciClk),
    .strobe (strobe),
    .cpuT   (cpuT),
    .cpuC   (cpuC),
    .pciFree(pciFree),
    .pciOut (pciOut)
  );

endmodule

// File: rtl/clkStopSeq_chk.sv
module clkStopSeq_chk
  import clkStopSeq_pkg::*;
#(
  parameter int NUM_PCI = 6
) (
  input logic               cpuClk,
  input logic               pciClk,
  input logic               rstN,
  input gateStrobe_t        strobe,
  input logic               cpuT,
  input logic               cpuC,
  input logic               pciFree,
  input logic [NUM_PCI-1:0] pciOut
);

  // R8: the two legs of the pair are never high together.
  p_pair_exclusive_r8: assert property (@(posedge cpuClk) disable iff (!rstN)
    !(cpuT && cpuC));

  // R4 / R5: an off request from control leaves both legs low.
  p_cpu_off_low_r4: assert property (@(posedge cpuClk) disable iff (!rstN)
    strobe.cpuOff |-> (!cpuT && !cpuC));

  // R1: a stop request parks true high, complement low.
  p_stop_park_r1: assert property (@(posedge cpuClk) disable iff (!rstN)
    (strobe.cpuStop && !strobe.cpuOff) |-> (cpuT && !cpuC));

  // R3: a stoppable output never runs while the free output is held.
  p_free_covers_group_r3: assert property (@(negedge pciClk) disable iff (!rstN)
    (|pciOut) |-> pciFree);

  // R4: off request for the PCI domain holds every PCI output low.
  p_pci_off_low_r4: assert property (@(negedge pciClk) disable iff (!rstN)
    strobe.pciOff |-> (!pciFree && (pciOut == '0)));

endmodule

bind clkStopSeq clkStopSeq_chk #(.NUM_PCI(NUM_PCI)) u_chk (
  .cpuClk (cpuClk),
  .pciClk (pciClk),
  .rstN   (rstN),
  .strobe (strobe),
  .cpuT   (cpuT),
  .cpuC   (cpuC),
  .pciFree(pciFree),
  .pciOut (pciOut)
);

// File: tb/clkStopSeq_tb.sv
module clkStopSeq_tb;

  localparam int NUM_PCI = 6;

  logic cpuClk = 1'b0;
  logic pciClk = 1'b0;
  logic rstN = 1'b0;
  logic cpuStopN = 1'b1;
  logic pciStopN = 1'b1;
  logic pdN = 1'b1;
  logic pwrGoodN = 1'b0;
  logic cpuT, cpuC, pciFree;
  logic [NUM_PCI-1:0] pciOut;

  int checks = 0;
  int errors = 0;
  logic checksOn = 1'b0;
  logic enabledExp = 1'b0;
  logic pgPhase = 1'b0;

  // 100 MHz processor source; PCI source at one third of it.
  always #5  cpuClk = ~cpuClk;
  always #15 pciClk = ~pciClk;

  clkStopSeq #(.NUM_PCI(NUM_PCI), .SYNC_STAGES(2)) u_dut (
    .cpuClk(cpuClk), .pciClk(pciClk), .rstN(rstN),
    .cpuStopN(cpuStopN), .pciStopN(pciStopN), .pdN(pdN), .pwrGoodN(pwrGoodN),
    .cpuT(cpuT), .cpuC(cpuC), .pciFree(pciFree), .pciOut(pciOut)
  );

  // Reference: a request counts from the second falling edge of its source.
  logic cs1 = 1, cs2 = 1, cp1 = 1, cp2 = 1, cpuRel = 0;
  logic ps1 = 1, ps2 = 1, pp1 = 1, pp2 = 1;

  always @(negedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      cs1 <= 1; cs2 <= 1; cp1 <= 1; cp2 <= 1; cpuRel <= 0;
    end else begin
      cs1 <= cpuStopN; cs2 <= cs1; cp1 <= pdN; cp2 <= cp1;
      cpuRel <= !cs2 && cs1;
    end
  end

  always @(negedge pciClk or negedge rstN) begin
    if (!rstN) begin
      ps1 <= 1; ps2 <= 1; pp1 <= 1; pp2 <= 1;
    end else begin
      ps1 <= pciStopN; ps2 <= ps1; pp1 <= pdN; pp2 <= pp1;
    end
  end

  function automatic logic [1:0] expPair(input logic off, input logic stop,
                                         input logic lvl);
    if (off)       return 2'b00;
    else if (stop) return 2'b10;
    else           return {lvl, ~lvl};
  endfunction

  function automatic logic [NUM_PCI:0] expPci(input logic off, input logic stop,
                                              input logic lvl);
    logic freeV, grpV;
    freeV = lvl & ~off;
    grpV  = lvl & ~off & ~stop;
    return {freeV, {NUM_PCI{grpV}}};
  endfunction

  task automatic check(input string tag, input logic [NUM_PCI:0] act,
                       input logic [NUM_PCI:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic checkCpu(input logic lvl);
    logic off, stop;
    string tag;
    off  = !enabledExp || !cp2;
    stop = !cs2;
    if (!enabledExp)      tag = "R5 cpu";
    else if (!cp2)        tag = "R4 cpu";
    else if (stop)        tag = "R1 cpu";
    else if (pgPhase)     tag = "R6 cpu";
    else if (cpuRel)      tag = "R2 cpu";
    else                  tag = "R8 cpu";
    check(tag, {{(NUM_PCI-1){1'b0}}, cpuT, cpuC},
          {{(NUM_PCI-1){1'b0}}, expPair(off, stop, lvl)});
  endtask

  task automatic checkPci(input logic lvl);
    logic off, stop;
    string tag;
    off  = !enabledExp || !pp2;
    stop = !ps2;
    if (!enabledExp)      tag = "R5 pci";
    else if (!pp2)        tag = "R4 pci";
    else if (stop)        tag = "R3 pci";
    else if (pgPhase)     tag = "R6 pci";
    else if (!cs2)        tag = "R9 pci";
    else                  tag = "R8 pci";
    check(tag, {pciFree, pciOut}, expPci(off, stop, lvl));
  endtask

  always @(posedge cpuClk) begin #2; if (checksOn) checkCpu(1'b1); end
  always @(negedge cpuClk) begin #2; if (checksOn) checkCpu(1'b0); end
  always @(posedge pciClk) begin #2; if (checksOn) checkPci(1'b1); end
  always @(negedge pciClk) begin #2; if (checksOn) checkPci(1'b0); end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge cpuClk);
      #3;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    // R7: reset state.
    #50;
    check("R7 reset", {pciFree, pciOut}, '0);
    check("R7 reset", {{(NUM_PCI-1){1'b0}}, cpuT, cpuC}, '0);
    #53 rstN = 1'b1;
    checksOn = 1'b1;
    // R5: power-good still low, then high: outputs stay low.
    waitCyc(10);
    pwrGoodN = 1'b1;
    waitCyc(12);
    // First fall: enable both domains, skip the sync window.
    checksOn = 1'b0;
    pwrGoodN = 1'b0;
    waitCyc(20);
    enabledExp = 1'b1;
    checksOn   = 1'b1;
    waitCyc(10);
    // R6: later power-good activity ignored.
    pgPhase = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pwrGoodN = 1'b1; waitCyc(8);
      pwrGoodN = 1'b0; waitCyc(8);
    end
    pgPhase = 1'b0;
    // Directed R1/R2, R3, R4 and overlap.
    cpuStopN = 1'b0; waitCyc(10); cpuStopN = 1'b1; waitCyc(10);
    pciStopN = 1'b0; waitCyc(15); pciStopN = 1'b1; waitCyc(15);
    cpuStopN = 1'b0; pdN = 1'b0; waitCyc(15); pdN = 1'b1; waitCyc(10);
    cpuStopN = 1'b1; waitCyc(10);
    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(7) == 0) cpuStopN = ~cpuStopN;
      if ($urandom_range(11) == 0) pciStopN = ~pciStopN;
      if ($urandom_range(23) == 0) pdN = ~pdN;
      if ($urandom_range(15) == 0) pwrGoodN = ~pwrGoodN;
      waitCyc(1);
    end
    checksOn = 1'b0;
    waitCyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule